// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block is the device-side command interpreter for the erase path of a byte-wide NOR flash array of 128K x 8 split into eight uniform 16 KB sectors. It watches single-cycle write strobes with their address and data, recognises the two six-write erase sequences, and then runs a timed busy interval that stands in for the internal erase. Memory cells, programming and identification commands lie outside the block. The array value for a read is supplied by the storage next to it on `arr_data`, and the block either passes that value through or substitutes a status byte.

A whole-array erase starts as soon as its sixth write arrives. A sector erase first opens a collection window. Each further sector-erase write during the window adds one sector to the erase buffer and restarts the window. Any other write during the window abandons the operation. When the window lapses, the busy interval runs through three phases: fill with zeros, verify, and wipe. Every write is ignored while this runs. When it ends, the buffer is released and reads return array data again.

The controller has ten states. ST_IDLE moves to ST_KEY1 on the first key write. The sequence then advances through ST_KEY2, ST_ARMED, ST_KEY4 and ST_KEY5, one matching write at a time, and any mismatching write from these states returns to ST_IDLE. From ST_KEY5 the chip command enters ST_FILL and the sector command enters ST_COLLECT. ST_COLLECT stays put on a sector write, which restarts the timer. It falls back to ST_IDLE on any other write, and moves to ST_FILL when the timer lapses. ST_FILL, ST_VERIFY and ST_WIPE each last one busy interval, and ST_WIPE returns to ST_IDLE.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, `sector_sel` is 0, `busy`, `win_open` and `erase_phase` are 0, and a read returns `arr_data`.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 start a chip erase. After the edge that samples the sixth write, `busy`=1, `erase_phase`=1 and every `sector_sel` bit is 1. Key addresses are compared on all address bits below the sector field [16:14].
- R3: A write that does not match the next expected step of either sequence returns the decoder to idle, and no erase follows.
- R4: A sixth write of 0x30, at any address, opens the collection window (`win_open`=1) and sets `sector_sel` bit number addr[16:14].
- R5: During the window, every 0x30 write, in any sector order, sets that sector's bit without clearing the others and restarts the window.
- R6: Any write other than 0x30 during the window clears `sector_sel`, closes the window and returns reads to array data. No erase follows.
- R7: The window closes and `busy` rises exactly WIN_CYCLES edges after the last accepted sector write.
- R8: The busy interval runs the phases 1 (zero fill), 2 (verify) and 3 (wipe), each lasting BUSY_CYCLES edges. It then drops `busy` and clears `sector_sel`.
- R9: While `busy`=1, writes have no effect on `sector_sel`, `erase_phase` or the timing of the interval.
- R10: A read during the window or the busy interval returns a status byte: bit 7 = 0, bit 3 = 1 once erasing has begun (0 inside the window), bits 5, 4 and 2:0 = 0.
- R11: Status bit 6 inverts on every successive status read, starting at 1 after reset. Reads outside the window and the busy interval, including those between key writes, return `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write per sampled high cycle |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data (command byte) |
| rd_en | input | 1 | Read request |
| arr_data | input | 8 | Array byte for the current read, from the storage |
| rd_data | output | 8 | Registered read result: array byte or status byte |
| sector_sel | output | 8 | Erase buffer, one bit per sector |
| win_open | output | 1 | Sector collection window is open |
| busy | output | 1 | Internal erase in progress |
| erase_phase | output | 2 | 0 none, 1 zero fill, 2 verify, 3 wipe |

## Verification
Every write acts on the edge that samples it, so `win_open`, `sector_sel` and `busy` are checked at that same edge. The expiry of the window is checked at the edge WIN_CYCLES after the last accepted sector write and at the edge before it. Each phase boundary falls a whole multiple of BUSY_CYCLES after `busy` rises. Read results appear one edge after `rd_en` is sampled and reflect the state before that edge. The driver computes the target edge of each expectation from the edge count it reads at the falling clock edge and queues it before that edge occurs. The monitor compares only those queued items whose edge has just passed, shortly after each rising edge.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_ARMED,
        ST_KEY4,
        ST_KEY5,
        ST_COLLECT,
        ST_FILL,
        ST_VERIFY,
        ST_WIPE
    } ecd_state_t;

    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_VERIFY = 2'd2,
        PH_WIPE   = 2'd3
    } ecd_phase_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_SETUP   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;

    localparam int KEY_ADDR_HI = 'h555;
    localparam int KEY_ADDR_LO = 'h2AA;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic setup;
        logic chip;
        logic sector;
    } ecd_cmd_t;

endpackage

// File: rtl/erase_cmd_match.sv
module erase_cmd_match
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int SECT_BITS = 3
) (
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output ecd_cmd_t             cmd,
    output logic [SECT_BITS-1:0] sect_idx
);
    localparam int OFF_W = ADDR_W - SECT_BITS;

    logic [OFF_W-1:0] offset;
    logic             at_hi;
    logic             at_lo;

    assign offset   = wr_addr[OFF_W-1:0];
    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_BITS];
    assign at_hi    = (offset == OFF_W'(KEY_ADDR_HI));
    assign at_lo    = (offset == OFF_W'(KEY_ADDR_LO));

    always_comb begin
        cmd.key_a  = at_hi && (wr_data == KEY_FIRST);
        cmd.key_b  = at_lo && (wr_data == KEY_SECOND);
        cmd.setup  = at_hi && (wr_data == OP_SETUP);
        cmd.chip   = at_hi && (wr_data == OP_CHIP);
        cmd.sector = (wr_data == OP_SECTOR);
    end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int TMR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_status_port.sv
module erase_status_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic [7:0] arr_data,
    input  logic       stat_en,
    input  logic       started,
    output logic [7:0] rd_data
);
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q   <= 1'b0;
            rd_data <= '0;
        end else if (rd_en) begin
            if (stat_en) begin
                tog_q   <= ~tog_q;
                rd_data <= {1'b0, ~tog_q, 2'b00, started, 3'b000};
            end else begin
                rd_data <= arr_data;
            end
        end
    end
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int SECT_BITS   = 3,
    parameter int WIN_CYCLES  = 50,
    parameter int BUSY_CYCLES = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic                        rd_en,
    input  logic [7:0]                  arr_data,
    output logic [7:0]                  rd_data,
    output logic [(1<<SECT_BITS)-1:0]   sector_sel,
    output logic                        win_open,
    output logic                        busy,
    output logic [1:0]                  erase_phase
);
    localparam int NUM_SECT = 1 << SECT_BITS;
    localparam int TMAX     = (WIN_CYCLES > BUSY_CYCLES) ? WIN_CYCLES : BUSY_CYCLES;
    localparam int TMR_W    = $clog2(TMAX + 1);

    ecd_state_t           state_q;
    ecd_state_t           state_d;
    ecd_cmd_t             cmd;
    ecd_phase_t           phase;
    logic [SECT_BITS-1:0] sect_idx;
    logic                 restart;
    logic                 tmr_load;
    logic [TMR_W-1:0]     tmr_val;
    logic                 tmr_done;
    logic                 enter_timed;
    logic                 to_blank;
    logic [NUM_SECT-1:0]  sel_q;

    erase_cmd_match #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS)
    ) u_match (
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd      (cmd),
        .sect_idx (sect_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and window restart
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && cmd.key_a) state_d = ST_KEY1;
            end
            ST_KEY1: begin
                if (wr_en) state_d = cmd.key_b ? ST_KEY2 : ST_IDLE;
            end
            ST_KEY2: begin
                if (wr_en) state_d = cmd.setup ? ST_ARMED : ST_IDLE;
            end
            ST_ARMED: begin
                if (wr_en) state_d = cmd.key_a ? ST_KEY4 : ST_IDLE;
            end
            ST_KEY4: begin
                if (wr_en) state_d = cmd.key_b ? ST_KEY5 : ST_IDLE;
            end
            ST_KEY5: begin
                if (wr_en) begin
                    if (cmd.chip)        state_d = ST_FILL;
                    else if (cmd.sector) state_d = ST_COLLECT;
                    else                 state_d = ST_IDLE;
                end
            end
            ST_COLLECT: begin
                if (wr_en) begin
                    if (cmd.sector) restart = 1'b1;
                    else            state_d = ST_IDLE;
                end else if (tmr_done) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (tmr_done) state_d = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (tmr_done) state_d = ST_WIPE;
            end
            ST_WIPE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign enter_timed = (state_d != state_q) &&
                         (state_d inside {ST_COLLECT, ST_FILL, ST_VERIFY, ST_WIPE});
    assign tmr_load    = restart || enter_timed;
    assign tmr_val     = (state_d == ST_COLLECT) ? TMR_W'(WIN_CYCLES - 1)
                                                 : TMR_W'(BUSY_CYCLES - 1);

    erase_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // erase buffer
    assign to_blank = state_d inside {ST_IDLE, ST_KEY1, ST_KEY2, ST_ARMED, ST_KEY4, ST_KEY5};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (to_blank) begin
            sel_q <= '0;
        end else if (wr_en && (state_q == ST_KEY5) && cmd.chip) begin
            sel_q <= '1;
        end else if (wr_en && cmd.sector &&
                     ((state_q == ST_KEY5) || (state_q == ST_COLLECT))) begin
            sel_q[sect_idx] <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        win_open = 1'b0;
        busy     = 1'b0;
        phase    = PH_NONE;
        unique case (state_q)
            ST_COLLECT: win_open = 1'b1;
            ST_FILL: begin
                busy  = 1'b1;
                phase = PH_FILL;
            end
            ST_VERIFY: begin
                busy  = 1'b1;
                phase = PH_VERIFY;
            end
            ST_WIPE: begin
                busy  = 1'b1;
                phase = PH_WIPE;
            end
            default: ;
        endcase
    end

    assign erase_phase = phase;
    assign sector_sel  = sel_q;

    erase_status_port u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .arr_data (arr_data),
        .stat_en  (busy || win_open),
        .started  (busy),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/erase_cmd_decoder_chk.sv
module erase_cmd_decoder_chk #(
    parameter int NUM_SECT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [7:0]          rd_data,
    input logic [NUM_SECT-1:0] sector_sel,
    input logic                win_open,
    input logic                busy,
    input logic [1:0]          erase_phase
);
    a_r9_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(sector_sel)));

    a_r8_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sector_sel == '0));

    a_r8_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || (erase_phase >= $past(erase_phase))));

    a_r8_start_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (erase_phase == 2'd1));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && win_open));

    a_r5_window_holds_sector: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (sector_sel != '0));

    a_r6_blank_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !win_open) |-> (sector_sel == '0));

    a_r10_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy)) |-> (!rd_data[7] && rd_data[3]));
endmodule

bind erase_cmd_decoder erase_cmd_decoder_chk #(
    .NUM_SECT (1 << SECT_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .sector_sel  (sector_sel),
    .win_open    (win_open),
    .busy        (busy),
    .erase_phase (erase_phase)
);

// File: tb/sim_erase_cmd_decoder.sv
module sim_erase_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 12;
    localparam int BSY  = 6;
    localparam int AW   = 17;
    localparam int SB   = 3;
    localparam int NS   = 1 << SB;

    logic          clk;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          rd_en;
    logic [7:0]    arr_data;
    logic [7:0]    rd_data;
    logic [NS-1:0] sector_sel;
    logic          win_open;
    logic          busy;
    logic [1:0]    erase_phase;

    erase_cmd_decoder #(
        .ADDR_W      (AW),
        .SECT_BITS   (SB),
        .WIN_CYCLES  (WIN),
        .BUSY_CYCLES (BSY)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .arr_data    (arr_data),
        .rd_data     (rd_data),
        .sector_sel  (sector_sel),
        .win_open    (win_open),
        .busy        (busy),
        .erase_phase (erase_phase)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int            cyc;
        string         req;
        bit            is_rd;
        logic [NS-1:0] sel;
        logic          bsy;
        logic          win;
        logic [1:0]    ph;
        logic [7:0]    rd;
    } item_t;

    item_t sb_q[$];
    int    ecnt   = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    tog    = 1'b0;

    // monitor: compares queued items right after their edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            ecnt++;
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].cyc < ecnt) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s: stale expectation for edge %0d (now %0d)",
                             sb_q[i].req, sb_q[i].cyc, ecnt);
                    sb_q.delete(i);
                end else if (sb_q[i].cyc == ecnt) begin
                    n_chk++;
                    if (sb_q[i].is_rd) begin
                        if (rd_data !== sb_q[i].rd) begin
                            n_fail++;
                            $display("FAIL %s edge %0d: rd_data actual %h expected %h",
                                     sb_q[i].req, ecnt, rd_data, sb_q[i].rd);
                        end
                    end else if (sector_sel !== sb_q[i].sel || busy !== sb_q[i].bsy ||
                                 win_open !== sb_q[i].win || erase_phase !== sb_q[i].ph) begin
                        n_fail++;
                        $display("FAIL %s edge %0d: actual sel=%h busy=%b win=%b ph=%0d expected sel=%h busy=%b win=%b ph=%0d",
                                 sb_q[i].req, ecnt, sector_sel, busy, win_open, erase_phase,
                                 sb_q[i].sel, sb_q[i].bsy, sb_q[i].win, sb_q[i].ph);
                    end
                    sb_q.delete(i);
                end
            end
        end
    end

    task automatic expst(input int c, input string r, input logic [NS-1:0] s,
                         input logic b, input logic w, input logic [1:0] p);
        item_t it;
        it.cyc = c; it.req = r; it.is_rd = 1'b0;
        it.sel = s; it.bsy = b; it.win = w; it.ph = p; it.rd = '0;
        sb_q.push_back(it);
    endtask

    task automatic exprd(input int c, input string r, input logic [7:0] v);
        item_t it;
        it.cyc = c; it.req = r; it.is_rd = 1'b1;
        it.sel = '0; it.bsy = 1'b0; it.win = 1'b0; it.ph = 2'd0; it.rd = v;
        sb_q.push_back(it);
    endtask

    function automatic logic [7:0] stat(input logic d3);
        tog = ~tog;
        return {1'b0, tog, 2'b00, d3, 3'b000};
    endfunction

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
    endtask

    task automatic wr_go(input logic [AW-1:0] a, input logic [7:0] d, output int e);
        @(negedge clk);
        rd_en   = 1'b0;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        e       = ecnt + 1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        int e;
        wr_go(a, d, e);
        quiet(1);
    endtask

    task automatic rd_chk(input logic [7:0] arr, input logic [7:0] expv, input string r);
        @(negedge clk);
        wr_en    = 1'b0;
        rd_en    = 1'b1;
        arr_data = arr;
        exprd(ecnt + 1, r, expv);
        quiet(1);
    endtask

    task automatic unlock5();
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
        wr(17'h00555, 8'h80);
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
    endtask

    initial begin
        int e6, a1, a2, a3, x, w;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; wr_data = '0; arr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expst(ecnt + 1, "R1", '0, 1'b0, 1'b0, 2'd0);
        rd_chk(8'h5A, 8'h5A, "R1");

        // chip erase with reads and stray writes while busy
        unlock5();
        wr_go(17'h00555, 8'h10, e6);
        expst(e6,         "R2", 8'hFF, 1'b1, 1'b0, 2'd1);
        expst(e6 + BSY,   "R8", 8'hFF, 1'b1, 1'b0, 2'd2);
        expst(e6 + 9,     "R9", 8'hFF, 1'b1, 1'b0, 2'd2);
        expst(e6 + 2*BSY, "R8", 8'hFF, 1'b1, 1'b0, 2'd3);
        expst(e6 + 3*BSY - 1, "R9", 8'hFF, 1'b1, 1'b0, 2'd3);
        expst(e6 + 3*BSY, "R8", '0, 1'b0, 1'b0, 2'd0);
        quiet(1);
        rd_chk(8'h3C, stat(1'b1), "R10");
        rd_chk(8'h3C, stat(1'b1), "R11");
        wr(17'h0C000, 8'h30);
        wr(17'h00555, 8'hF0);
        wr(17'h00555, 8'hAA);
        quiet(10);
        rd_chk(8'h3C, 8'h3C, "R11");

        // mismatch at step 3, then a truncated replay
        wr(17'h00555, 8'hAA);
        rd_chk(8'hC3, 8'hC3, "R11");
        wr(17'h002AA, 8'h55);
        wr(17'h00123, 8'h80);
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
        wr_go(17'h00555, 8'h10, x);
        expst(x,     "R3", '0, 1'b0, 1'b0, 2'd0);
        expst(x + 2, "R3", '0, 1'b0, 1'b0, 2'd0);
        quiet(3);
        // mismatch at step 5 (right data, wrong address)
        wr(17'h00555, 8'hAA);
        wr(17'h002AA, 8'h55);
        wr(17'h00555, 8'h80);
        wr(17'h00555, 8'hAA);
        wr(17'h00555, 8'h55);
        wr_go(17'h00555, 8'h30, x);
        expst(x, "R3", '0, 1'b0, 1'b0, 2'd0);
        quiet(3);

        // sector erase collecting four sectors in mixed order
        unlock5();
        wr_go(17'h14123, 8'h30, e6);
        expst(e6, "R4", 8'h20, 1'b0, 1'b1, 2'd0);
        quiet(1);
        wr_go(17'h08000, 8'h30, a1);
        expst(a1, "R5", 8'h24, 1'b0, 1'b1, 2'd0);
        quiet(1);
        wr_go(17'h1FFFF, 8'h30, a2);
        expst(a2, "R5", 8'hA4, 1'b0, 1'b1, 2'd0);
        quiet(1);
        wr_go(17'h00000, 8'h30, a3);
        expst(a3,               "R5", 8'hA5, 1'b0, 1'b1, 2'd0);
        expst(e6 + WIN,         "R5", 8'hA5, 1'b0, 1'b1, 2'd0);
        expst(a3 + WIN - 1,     "R7", 8'hA5, 1'b0, 1'b1, 2'd0);
        expst(a3 + WIN,         "R7", 8'hA5, 1'b1, 1'b0, 2'd1);
        expst(a3 + WIN + BSY,   "R8", 8'hA5, 1'b1, 1'b0, 2'd2);
        expst(a3 + WIN + 3*BSY - 1, "R9", 8'hA5, 1'b1, 1'b0, 2'd3);
        expst(a3 + WIN + 3*BSY, "R8", '0, 1'b0, 1'b0, 2'd0);
        quiet(1);
        rd_chk(8'h99, stat(1'b0), "R10");
        quiet(10);
        wr_go(17'h04000, 8'h30, w);
        expst(w + 1, "R9", 8'hA5, 1'b1, 1'b0, 2'd1);
        quiet(1);
        rd_chk(8'h99, stat(1'b1), "R10");
        quiet(25);

        // abort inside the window
        unlock5();
        wr_go(17'h0C000, 8'h30, e6);
        expst(e6, "R4", 8'h08, 1'b0, 1'b1, 2'd0);
        quiet(1);
        wr_go(17'h00555, 8'hF0, x);
        expst(x,           "R6", '0, 1'b0, 1'b0, 2'd0);
        expst(x + WIN + 2, "R6", '0, 1'b0, 1'b0, 2'd0);
        quiet(1);
        rd_chk(8'h77, 8'h77, "R6");
        quiet(WIN + 4);

        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: %0d expectations never compared, expected 0",
                     sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule